// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal. It counts rising edges of the chosen input during a gate window whose length is set in system-clock cycles. The result is a 20-bit binary count, which software reads as three byte-wide values. Two inputs are available. The FM input passes through a divide-by-two prescaler, so its count is half the number of edges. The AM input is counted edge for edge.

A measurement starts with a one-cycle start strobe. The strobe clears the counter and the prescaler, clears the done and overflow flags, and opens the gate. When the gate closes, the count is copied into the result registers and done is raised. A start strobe that arrives while a measurement is running throws that measurement away and begins a new one.

The selected input passes through a two-flop synchronizer, and its rising edges are detected in the system-clock domain. The input must stay slower than half the system clock. With the default width, a gate of 4 ms at 125 MHz is 500000 cycles, which fits in the gate-length field.

Top module: `gated_if_counter`

## Requirements
- R1: With selAm = 0 (FM input), every second synchronized rising edge inside the gate is counted; the prescaler phase is cleared by start. A stream that gives 42800 edges in the gate yields 21400 (0x05398), the value of a 10.7 MHz input over a 4 ms gate.
- R2: With selAm = 1 (AM input), every synchronized rising edge inside the gate is counted. 1800 edges yield 0x00708, the value of a 450 kHz input over a 4 ms gate.
- R3: Timing of the gate and of done:
  - The gate lasts gateLen system-clock cycles after the cycle in which start is sampled.
  - done rises at the clock edge that ends that window, and not one cycle earlier.
  - A gateLen of 0 behaves as 1.
  - gateLen reaches 2^GATE_W-1, which is at least 500000 (4 ms at 125 MHz).
- R4: Layout of the result across the three registers:
  - resHi[3:0] holds count bits 19..16, and resHi[7:4] reads 0.
  - resMid holds bits 15..8.
  - resLo holds bits 7..0.
- R5: A start strobe clears done and overflow at the next edge. The result registers keep the previous measurement until the next result latch.
- R6: The count saturates at 2^CNT_W-1. If one or more edges arrive while the count is saturated, overflow is 1 at the latch. A count that exactly reaches 2^CNT_W-1 leaves overflow at 0.
- R7: A start strobe during a running measurement restarts it with a full new gate. This also holds when the strobe falls in the last gate cycle: start wins, done stays 0, and the results are not updated.
- R8: After reset, done = 0, overflow = 0 and all result registers read 0.
- R9: The input that is not selected has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fmIn | input | 1 | FM IF input, divided by two before counting |
| amIn | input | 1 | AM IF input, counted directly |
| selAm | input | 1 | Input select: 0 selects fmIn, 1 selects amIn |
| gateLen | input | GATE_W | Gate length in system clocks (0 acts as 1) |
| start | input | 1 | One-cycle strobe that starts or restarts a measurement |
| done | output | 1 | Result valid since the last gate closed |
| overflow | output | 1 | The last measurement saturated |
| resHi | output | 8 | Count bits 19..16 in the low nibble |
| resMid | output | 8 | Count bits 15..8 |
| resLo | output | 8 | Count bits 7..0 |

## Verification
Two of this block's functions can fall in the same cycle: the restart strobe and the result latch at the end of the gate. The bench provokes this by pulsing start so that it is sampled on the very edge that would close a running gate. It then judges the outcome at the ports. done must stay low, and the result registers must still show the measurement before the aborted one. After one further full gate, the count from the new window must appear.

// File: rtl/gated_if_counter_pkg.sv
package gated_if_counter_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic clr;    // clear counter, prescaler and flags
    logic gate;   // gate open this cycle
    logic latch;  // last gate cycle: capture the result
  } ifcStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ifcState_e;

endpackage

// File: rtl/gated_if_counter_ctrl.sv
module gated_if_counter_ctrl
  import gated_if_counter_pkg::*;
#(
  parameter int GATE_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [GATE_W-1:0] gateLen,
  output ifcStrobe_t        strobe
);

  localparam logic [GATE_W-1:0] ONE = GATE_W'(1);

  ifcState_e         state;
  logic [GATE_W-1:0] timer;
  logic [GATE_W-1:0] loadVal;
  logic              lastCycle;

  assign loadVal   = (gateLen == '0) ? ONE : gateLen;
  assign lastCycle = (state == ST_RUN) && (timer == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      timer <= '0;
    end else if (start) begin
      state <= ST_RUN;
      timer <= loadVal;
    end else if (state == ST_RUN) begin
      timer <= timer - ONE;
      if (timer == ONE) state <= ST_IDLE;
    end
  end

  // start has priority over the closing of a running gate
  always_comb begin
    strobe.clr   = start;
    strobe.gate  = (state == ST_RUN) && !start;
    strobe.latch = lastCycle && !start;
  end

  // R3: a running gate always has cycles left
  a_r3_timer_live: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (timer != '0));

  // R3: the latch ends the run
  a_r3_latch_ends_run: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |=> (state == ST_IDLE));

  // R7: a start always leaves a full gate loaded
  a_r7_restart_loads: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (state == ST_RUN) && (timer == $past(loadVal)));

endmodule

// File: rtl/gated_if_counter_dp.sv
module gated_if_counter_dp
  import gated_if_counter_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fmIn,
  input  logic             amIn,
  input  logic             selAm,
  input  ifcStrobe_t       strobe,
  output logic [CNT_W-1:0] result,
  output logic             done,
  output logic             overflow
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int SYNC_N = 3;

  logic [SYNC_N-1:0] syncQ;
  logic              selIn;
  logic              rise;
  logic              preTgl;
  logic              countEv;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  cntNext;
  logic              ovAcc;
  logic              ovNext;

  assign selIn = selAm ? amIn : fmIn;

  // two synchronizer flops plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_N-2:0], selIn};
  end

  assign rise = syncQ[1] & ~syncQ[2];

  // divide-by-two prescaler, used only on the FM path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             preTgl <= 1'b0;
    else if (strobe.clr)                   preTgl <= 1'b0;
    else if (strobe.gate && rise && !selAm) preTgl <= ~preTgl;
  end

  assign countEv = strobe.gate && rise && (selAm || preTgl);

  always_comb begin
    cntNext = count;
    ovNext  = ovAcc;
    if (countEv) begin
      if (count == CNT_MAX) ovNext  = 1'b1;
      else                  cntNext = count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      ovAcc <= 1'b0;
    end else if (strobe.clr) begin
      count <= '0;
      ovAcc <= 1'b0;
    end else begin
      count <= cntNext;
      ovAcc <= ovNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      done     <= 1'b0;
      overflow <= 1'b0;
    end else if (strobe.clr) begin
      done     <= 1'b0;
      overflow <= 1'b0;
    end else if (strobe.latch) begin
      result   <= cntNext;
      overflow <= ovNext;
      done     <= 1'b1;
    end
  end

  // R5: start clears done
  a_r5_start_clears_done: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> !done);

  // R5: results move only at a latch
  a_r5_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latch |=> $stable(result));

  // R3: a latch raises done
  a_r3_latch_sets_done: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |=> done);

  // R6: a saturated count stays saturated
  a_r6_sat_hold: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_MAX) && !strobe.clr |=> (count == CNT_MAX));

  // R6: overflow is recorded only from a full counter
  a_r6_no_early_overflow: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovAcc) |-> ($past(count) == CNT_MAX));

  // R2: the count grows by at most one per cycle
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clr && (count != CNT_MAX) |=> (count - $past(count)) <= CNT_W'(1));

  // R1: on the FM path the counter never moves on a first-phase edge
  a_r1_prescale: assert property (@(posedge clk) disable iff (!rstN)
    strobe.gate && rise && !selAm && !preTgl |=> $stable(count));

endmodule

// File: rtl/gated_if_counter.sv
module gated_if_counter
  import gated_if_counter_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int GATE_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fmIn,
  input  logic              amIn,
  input  logic              selAm,
  input  logic [GATE_W-1:0] gateLen,
  input  logic              start,
  output logic              done,
  output logic              overflow,
  output logic [7:0]        resHi,
  output logic [7:0]        resMid,
  output logic [7:0]        resLo
);

  localparam int OUT_W = 24;

  ifcStrobe_t       strobe;
  logic [CNT_W-1:0] result;
  logic [OUT_W-1:0] resWide;

  gated_if_counter_ctrl #(.GATE_W(GATE_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .gateLen (gateLen),
    .strobe  (strobe)
  );

  gated_if_counter_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .fmIn     (fmIn),
    .amIn     (amIn),
    .selAm    (selAm),
    .strobe   (strobe),
    .result   (result),
    .done     (done),
    .overflow (overflow)
  );

  assign resWide = OUT_W'(result);
  assign resHi   = resWide[23:16];
  assign resMid  = resWide[15:8];
  assign resLo   = resWide[7:0];

  // R4: upper nibble of the high register is zero
  a_r4_hi_nibble: assert property (@(posedge clk) disable iff (!rstN)
    resHi[7:4] == 4'h0);

endmodule

// File: tb/gated_if_counter_bench.sv
`timescale 1ns/1ps
module gated_if_counter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fmIn = 1'b0, amIn = 1'b0, selAm = 1'b0, start = 1'b0;
  logic [19:0] gateLen = '0;
  logic        done, overflow;
  logic [7:0]  resHi, resMid, resLo;

  logic        nStart = 1'b0;
  logic [11:0] nGateLen = '0;
  logic        nDone, nOvf;
  logic [7:0]  nHi, nMid, nLo;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  bit fmOn = 1'b0, amOn = 1'b0;
  int period = 3;
  int ph = 0;

  always #4 clk = ~clk;  // 125 MHz

  gated_if_counter u_gated_if_counter (
    .clk(clk), .rstN(rstN), .fmIn(fmIn), .amIn(amIn), .selAm(selAm),
    .gateLen(gateLen), .start(start), .done(done), .overflow(overflow),
    .resHi(resHi), .resMid(resMid), .resLo(resLo)
  );

  gated_if_counter #(.CNT_W(8), .GATE_W(12)) u_gated_if_counter_narrow (
    .clk(clk), .rstN(rstN), .fmIn(1'b0), .amIn(amIn), .selAm(1'b1),
    .gateLen(nGateLen), .start(nStart), .done(nDone), .overflow(nOvf),
    .resHi(nHi), .resMid(nMid), .resLo(nLo)
  );

  // input generator: one-cycle high pulse every 'period' clocks
  always @(negedge clk) begin
    ph   <= (ph + 1 >= period) ? 0 : ph + 1;
    fmIn <= fmOn && (ph == 0);
    amIn <= amOn && (ph == 0);
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint res();
    return {resHi, resMid, resLo};
  endfunction

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulseNarrow();
    @(negedge clk) nStart = 1'b1;
    @(negedge clk) nStart = 1'b0;
  endtask

  task automatic runGate(input int g);
    pulseStart();
    repeat (g) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tReset();
    check(done == 1'b0, "R8 done", done, 0);
    check(overflow == 1'b0, "R8 overflow", overflow, 0);
    check(res() == 0, "R8 result", res(), 0);
  endtask

  task automatic tTiming();
    fmOn = 0; amOn = 0; selAm = 1'b1;
    gateLen = 20'd5;
    pulseStart();
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R3 done early", done, 0);
    @(posedge clk); @(negedge clk);
    check(done == 1'b1, "R3 done at gate end", done, 1);
    gateLen = 20'd0;
    pulseStart();
    check(done == 1'b0, "R5 start clears done", done, 0);
    @(posedge clk); @(negedge clk);
    check(done == 1'b1, "R3 zero gate acts as one", done, 1);
    check(res() == 0, "R3 idle input count", res(), 0);
  endtask

  task automatic tFm();
    amOn = 0; fmOn = 1; period = 3; selAm = 1'b0;
    gateLen = 20'd128400;
    runGate(128400);
    check(done == 1'b1, "R1 done", done, 1);
    check(res() == 21400, "R1 fm count", res(), 21400);
    check(resHi == 8'h00, "R4 hi", resHi, 0);
    check(resMid == 8'h53, "R4 mid", resMid, 8'h53);
    check(resLo == 8'h98, "R4 lo", resLo, 8'h98);
    check(overflow == 1'b0, "R6 no overflow", overflow, 0);
  endtask

  task automatic tAm();
    fmOn = 0; amOn = 1; selAm = 1'b1;
    gateLen = 20'd5400;
    runGate(5400);
    check(res() == 1800, "R2 am count", res(), 1800);
    check(resMid == 8'h07, "R4 mid am", resMid, 7);
    check(resLo == 8'h08, "R4 lo am", resLo, 8);
  endtask

  task automatic tIgnore();
    selAm = 1'b1; fmOn = 1; amOn = 0;
    gateLen = 20'd300;
    runGate(300);
    check(res() == 0, "R9 fm ignored when am selected", res(), 0);
    selAm = 1'b0; fmOn = 0; amOn = 1;
    runGate(300);
    check(res() == 0, "R9 am ignored when fm selected", res(), 0);
  endtask

  task automatic tRestart();
    selAm = 1'b1; fmOn = 0; amOn = 1;
    gateLen = 20'd3000;
    pulseStart();
    repeat (999) @(posedge clk);
    pulseStart();
    repeat (2999) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R7 restart extends gate", done, 0);
    check(res() == 0, "R5 result held during run", res(), 0);
    @(posedge clk); @(negedge clk);
    check(done == 1'b1, "R7 restart done", done, 1);
    check(res() == 1000, "R7 restart count", res(), 1000);
  endtask

  task automatic tCollision();
    gateLen = 20'd2400;
    pulseStart();
    repeat (2399) @(posedge clk);
    pulseStart();  // sampled on the closing edge
    check(done == 1'b0, "R7 collision no done", done, 0);
    check(res() == 1000, "R7 collision result not latched", res(), 1000);
    repeat (2399) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R7 collision new gate running", done, 0);
    @(posedge clk); @(negedge clk);
    check(done == 1'b1, "R7 collision new gate done", done, 1);
    check(res() == 800, "R7 collision count", res(), 800);
  endtask

  task automatic tSaturate();
    amOn = 1; period = 3;
    nGateLen = 12'd768;
    pulseNarrow();
    repeat (768) @(posedge clk);
    @(negedge clk);
    check(nDone == 1'b1, "R6 narrow done", nDone, 1);
    check(nLo == 8'hFF, "R6 saturated value", nLo, 255);
    check(nOvf == 1'b1, "R6 overflow set", nOvf, 1);
    nGateLen = 12'd765;
    pulseNarrow();
    check(nOvf == 1'b0, "R5 start clears overflow", nOvf, 1'b0);
    check(nLo == 8'hFF, "R5 narrow result held", nLo, 255);
    repeat (765) @(posedge clk);
    @(negedge clk);
    check(nLo == 8'hFF && nMid == 0 && nHi == 0, "R6 exact full count", nLo, 255);
    check(nOvf == 1'b0, "R6 exact full no overflow", nOvf, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    tReset();
    tTiming();
    tFm();
    tAm();
    tIgnore();
    tRestart();
    tCollision();
    tSaturate();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule